// File: doc/BRIEF.md
# Load/Store Ordering Matrix

This block decides when each of several in-flight memory operations may go ahead. Every memory unit slot holds one operation: a load or a store, plus a short address tag. The tag is either a few high-order address bits or a cache-line index supplied by the caller. When an operation is issued into a free slot, the block records a blocking bit for every older busy operation that might touch the same memory. The test is deliberately conservative. Equal tags only mean that an overlap cannot be ruled out, and two loads are never treated as a conflict.

Each slot drives a read permission (loads) and a write permission (stores). These feed the function-unit dependency matrix as extra blocking terms. When an operation completes, its row and its column are cleared. Any slot waiting only on it gets its permission in the following cycle. With a tag width of zero, every load/store and store/store pair is treated as conflicting, which gives fully serialised ordering.

Top module: `ls_hazard_matrix`

## Requirements
- R1: After reset, no slot is busy and every read and write permission is low.
- R2: An issue to a slot that is already busy is ignored, and a completion for an idle slot has no effect.
- R3: A load is held while any older busy store has an equal tag, and a store is held while any older busy load has an equal tag.
- R4: A load is never held by another load, whatever the tags.
- R5: Stores with equal tags are granted in issue order: a younger store is held until the older one completes.
- R6: An operation whose tag differs from every older busy operation of the conflicting kind is permitted in the first cycle after it is issued.
- R7: When a slot completes, its own permission is low in the next cycle, and a slot held only by it is permitted in that same next cycle.
- R8: With tag width 0, every load/store and store/store pair is ordered by issue, regardless of the tag input.
- R9: The read permission is only ever high for a busy load, and the write permission only for a busy store.
- R10: Two permissions that are high in the same cycle never belong to a load/store or store/store pair with equal tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue a new memory operation this cycle |
| issueUnit | input | UNIT_W | Slot index receiving the operation |
| issueIsStore | input | 1 | 1 = store, 0 = load |
| issueTag | input | TAG_PW | Conflict tag (high address bits or line index) |
| doneValid | input | 1 | A slot completes this cycle |
| doneUnit | input | UNIT_W | Index of the completing slot |
| readOk | output | NUM_UNITS | Per-slot load permission |
| writeOk | output | NUM_UNITS | Per-slot store permission |

## Verification
A load-load pair with equal tags separates "loads never block" from a design that blocks on any tag match. A load followed by a store on the same tag, and the reverse, confirm that both kinds of opposite-type blocking are present. A pair of same-tag stores shows whether issue order is kept. Mixed traffic on different tags shows that unrelated operations suffer no delay. A second instance with zero tag width runs the same stimulus and must serialise everything except loads. Long random traffic on a small tag space is then compared cycle by cycle against an age-ordered model. This traffic includes issues to busy slots and completions for idle slots.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef struct packed {
    logic issueFire;
    logic doneFire;
  } lsmStrobe_t;
endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl #(
  parameter int NUM_UNITS = 4,
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                  issueValid,
  input  logic [UNIT_W-1:0]     issueUnit,
  input  logic                  doneValid,
  input  logic [UNIT_W-1:0]     doneUnit,
  input  logic [NUM_UNITS-1:0]  busyVec,
  output lsm_pkg::lsmStrobe_t   strobe,
  output logic [NUM_UNITS-1:0]  issueSel,
  output logic [NUM_UNITS-1:0]  doneSel
);
  always_comb begin
    strobe.issueFire = issueValid && !busyVec[issueUnit];
    strobe.doneFire  = doneValid && busyVec[doneUnit];
    issueSel = '0;
    doneSel  = '0;
    issueSel[issueUnit] = 1'b1;
    doneSel[doneUnit]   = 1'b1;
  end
endmodule

// File: rtl/lsm_datapath.sv
module lsm_datapath #(
  parameter int NUM_UNITS = 4,
  parameter int TAG_W     = 4,
  localparam int TAG_PW   = (TAG_W > 0) ? TAG_W : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lsm_pkg::lsmStrobe_t   strobe,
  input  logic [NUM_UNITS-1:0]  issueSel,
  input  logic [NUM_UNITS-1:0]  doneSel,
  input  logic                  issueIsStore,
  input  logic [TAG_PW-1:0]     issueTag,
  output logic [NUM_UNITS-1:0]  busyVec,
  output logic [NUM_UNITS-1:0]  storeVec,
  output logic [NUM_UNITS-1:0]  readOk,
  output logic [NUM_UNITS-1:0]  writeOk
);
  logic [NUM_UNITS-1:0] busyR, storeR;
  logic [TAG_PW-1:0]    tagR   [NUM_UNITS];
  logic [NUM_UNITS-1:0] blockR [NUM_UNITS];
  logic [NUM_UNITS-1:0] matchVec, conflictVec, issueHot, doneHot;

  assign issueHot = strobe.issueFire ? issueSel : '0;
  assign doneHot  = strobe.doneFire  ? doneSel  : '0;

  // Tag comparison variant: zero width treats every pair as a possible overlap
  for (genvar j = 0; j < NUM_UNITS; j++) begin : gMatch
    if (TAG_W == 0) begin : gAll
      assign matchVec[j] = 1'b1;
    end else begin : gCmp
      assign matchVec[j] = (tagR[j] == issueTag);
    end
    assign conflictVec[j] = busyR[j] && matchVec[j] && (issueIsStore || storeR[j]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR  <= '0;
      storeR <= '0;
      for (int i = 0; i < NUM_UNITS; i++) begin
        tagR[i]   <= '0;
        blockR[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_UNITS; i++) begin
        if (issueHot[i]) begin
          busyR[i]  <= 1'b1;
          storeR[i] <= issueIsStore;
          tagR[i]   <= issueTag;
          blockR[i] <= conflictVec & ~doneHot;
        end else if (doneHot[i]) begin
          busyR[i]  <= 1'b0;
          blockR[i] <= '0;
        end else begin
          blockR[i] <= blockR[i] & ~doneHot;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_UNITS; i++) begin : gGrant
    assign readOk[i]  = busyR[i] && !storeR[i] && !(|blockR[i]);
    assign writeOk[i] = busyR[i] &&  storeR[i] && !(|blockR[i]);
  end

  assign busyVec  = busyR;
  assign storeVec = storeR;
endmodule

// File: rtl/ls_hazard_matrix.sv
module ls_hazard_matrix #(
  parameter int NUM_UNITS = 4,
  parameter int TAG_W     = 4,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int TAG_PW   = (TAG_W > 0) ? TAG_W : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic [UNIT_W-1:0]     issueUnit,
  input  logic                  issueIsStore,
  input  logic [TAG_PW-1:0]     issueTag,
  input  logic                  doneValid,
  input  logic [UNIT_W-1:0]     doneUnit,
  output logic [NUM_UNITS-1:0]  readOk,
  output logic [NUM_UNITS-1:0]  writeOk
);
  lsm_pkg::lsmStrobe_t  strobe;
  logic [NUM_UNITS-1:0] issueSel, doneSel, busyVec, storeVec;

  lsm_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
    .issueValid(issueValid), .issueUnit(issueUnit),
    .doneValid(doneValid), .doneUnit(doneUnit),
    .busyVec(busyVec), .strobe(strobe),
    .issueSel(issueSel), .doneSel(doneSel)
  );

  lsm_datapath #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueSel(issueSel), .doneSel(doneSel),
    .issueIsStore(issueIsStore), .issueTag(issueTag),
    .busyVec(busyVec), .storeVec(storeVec),
    .readOk(readOk), .writeOk(writeOk)
  );
endmodule

// File: rtl/ls_hazard_matrix_checker.sv
module ls_hazard_matrix_checker #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic [UNIT_W-1:0]    issueUnit,
  input logic                 doneValid,
  input logic [UNIT_W-1:0]    doneUnit,
  input logic [NUM_UNITS-1:0] busyVec,
  input logic [NUM_UNITS-1:0] storeVec,
  input logic [NUM_UNITS-1:0] readOk,
  input logic [NUM_UNITS-1:0] writeOk
);
  assert_perm_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((readOk & ~(busyVec & ~storeVec)) == '0) && ((writeOk & ~(busyVec & storeVec)) == '0));

  assert_idle_none_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busyVec == '0) |-> ((readOk | writeOk) == '0));

  assert_done_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && busyVec[doneUnit]) |=>
      !readOk[$past(doneUnit)] && !writeOk[$past(doneUnit)]);

  assert_busy_issue_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && busyVec[issueUnit] && !doneValid) |=>
      busyVec[$past(issueUnit)] && (storeVec[$past(issueUnit)] == $past(storeVec[issueUnit])));

  assert_empty_issue_granted_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (busyVec == '0)) |=>
      (readOk[$past(issueUnit)] || writeOk[$past(issueUnit)]));
endmodule

bind ls_hazard_matrix ls_hazard_matrix_checker #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
  .doneValid(doneValid), .doneUnit(doneUnit), .busyVec(busyVec),
  .storeVec(storeVec), .readOk(readOk), .writeOk(writeOk)
);

// File: tb/ls_hazard_matrix_tb.sv
module ls_hazard_matrix_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic       iv = 1'b0, ist = 1'b0, dv = 1'b0;
  logic [1:0] iu = '0, du = '0;
  logic [3:0] itag = '0;
  logic [3:0] rdA, wrA, rdB, wrB;

  int checks = 0;
  int errors = 0;

  ls_hazard_matrix #(.NUM_UNITS(4), .TAG_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(iv), .issueUnit(iu), .issueIsStore(ist),
    .issueTag(itag), .doneValid(dv), .doneUnit(du), .readOk(rdA), .writeOk(wrA));

  ls_hazard_matrix #(.NUM_UNITS(4), .TAG_W(0)) u_dutSer (
    .clk(clk), .rstN(rstN), .issueValid(iv), .issueUnit(iu), .issueIsStore(ist),
    .issueTag(itag[0:0]), .doneValid(dv), .doneUnit(du), .readOk(rdB), .writeOk(wrB));

  // Behavioural age-ordered model; index 0 = tagged instance, 1 = zero-width tags
  bit mBusy [2][4];
  bit mSt   [2][4];
  int mTag  [2][4];
  int mSeq  [2][4];
  int seqCnt = 0;

  function automatic bit permit(int m, int i);
    if (!mBusy[m][i]) return 1'b0;
    for (int j = 0; j < 4; j++) begin
      if (j != i && mBusy[m][j] && mSeq[m][j] < mSeq[m][i] &&
          (mSt[m][i] || mSt[m][j]) && (m == 1 || mTag[m][j] == mTag[m][i]))
        return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic modelEdge();
    seqCnt++;
    for (int m = 0; m < 2; m++) begin
      bit wasBusy;
      wasBusy = mBusy[m][iu];
      if (dv && mBusy[m][du]) mBusy[m][du] = 1'b0;
      if (iv && !wasBusy) begin
        mBusy[m][iu] = 1'b1;
        mSt[m][iu]   = ist;
        mTag[m][iu]  = int'(itag);
        mSeq[m][iu]  = seqCnt;
      end
    end
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    logic [3:0] eR [2];
    logic [3:0] eW [2];
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 4; i++) begin
        eR[m][i] = permit(m, i) && !mSt[m][i];
        eW[m][i] = permit(m, i) &&  mSt[m][i];
      end
    chk({req, " readOk"}, rdA, eR[0]);
    chk({req, " writeOk"}, wrA, eW[0]);
    chk("R8 serial readOk", rdB, eR[1]);
    chk("R8 serial writeOk", wrB, eW[1]);
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare at the next fall
  task automatic step(bit v, int u, bit s, int t, bit d, int du_i, string req);
    iv = v; iu = 2'(u); ist = s; itag = 4'(t); dv = d; du = 2'(du_i);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll(req);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 readOk", rdA, 4'b0000);
    chk("R1 writeOk", wrA, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);

    // loads share a tag, then a store on that tag, then a load on another tag
    step(1, 0, 0, 3, 0, 0, "R6");  chk("R6 first load", rdA, 4'b0001);
    step(1, 1, 0, 3, 0, 0, "R4");  chk("R4 load-load", rdA, 4'b0011);
    step(1, 2, 1, 3, 0, 0, "R3");  chk("R3 store after loads", wrA, 4'b0000);
    step(1, 3, 0, 5, 0, 0, "R6");  chk("R6 other tag", rdA, 4'b1011);
    chk("R8 serial load held", rdB, 4'b0011);
    step(0, 0, 0, 0, 1, 0, "R7");  chk("R7 done drops", rdA, 4'b1010);
    step(0, 0, 0, 0, 1, 1, "R7");  chk("R7 store released", wrA, 4'b0100);
    step(0, 0, 0, 0, 1, 2, "R7");  chk("R8 serial load freed", rdB, 4'b1000);
    step(0, 0, 0, 0, 1, 3, "R7");  chk("R7 empty", rdA | wrA, 4'b0000);

    // stores share a tag, a store on another tag, a load behind the stores
    step(1, 0, 1, 7, 0, 0, "R6");  chk("R6 first store", wrA, 4'b0001);
    step(1, 1, 1, 7, 0, 0, "R5");  chk("R5 younger store held", wrA, 4'b0001);
    step(1, 2, 1, 8, 0, 0, "R6");  chk("R6 store other tag", wrA, 4'b0101);
    step(1, 3, 0, 7, 0, 0, "R3");  chk("R3 load after store", rdA, 4'b0000);
    step(0, 0, 0, 0, 1, 0, "R5");  chk("R5 store order", wrA, 4'b0110);
    chk("R3 load still held", rdA, 4'b0000);
    step(0, 0, 0, 0, 1, 1, "R7");  chk("R7 load released", rdA, 4'b1000);

    // issue to a busy slot and completion of an idle slot
    step(1, 3, 1, 7, 0, 0, "R2");  chk("R2 busy issue readOk", rdA, 4'b1000);
    chk("R2 busy issue writeOk", wrA, 4'b0100);
    step(0, 0, 0, 0, 1, 0, "R2");  chk("R2 idle done", rdA | wrA, 4'b1100);
    step(0, 0, 0, 0, 1, 2, "R7");
    step(0, 0, 0, 0, 1, 3, "R7");

    // mixed random traffic on a small tag space
    for (int k = 0; k < 600; k++)
      step(bit'($urandom % 2), int'($urandom % 4), bit'($urandom % 2), int'($urandom % 3),
           bit'(($urandom % 3) != 0), int'($urandom % 4), "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule